// File: doc/BRIEF.md
# Two-Level Page Walk Address Translator

This block turns a 32-bit linear address into a physical address. Three control flags decide what happens. One enables protection, one enables paging and one makes read-only pages binding on writes. A separate register holds the base of the top-level table, and another keeps the last linear address that faulted. With paging off, the linear address goes straight through and memory is not touched. With paging on, the block reads one entry from the top-level directory and one from the selected page table over a valid/ready read port. It then returns either the 4 KB page frame joined to the page offset, or a fault.

Only one translation runs at a time. The requester sees `busy_o` from the cycle after acceptance until the cycle after the response. The control flags and the directory base are sampled when a request is accepted. Any write to them after that point affects only later requests.

Top module: `pt_walk_top`

## Requirements
- R1: After reset, `ctl_o`, `base_o` and `fault_addr_o` read zero, and `busy_o`, `rsp_valid_o` and `mem_req_o` are low.
- R2: A control write sets the flags from the written word: protection enable from bit 0, write protect from bit 16 and paging enable from bit 31. `ctl_o` returns these three bits in the same positions and zero in every other bit. A write with bit 31 set and bit 0 clear is dropped as a whole and leaves all three flags unchanged.
- R3: With paging disabled, a request is answered in the cycle after acceptance with `rsp_paddr_o` equal to the linear address and no fault. No memory read is issued.
- R4: The first read of a walk goes to {directory base bits 31:12, linear bits 31:22, 2'b00}. `base_o` returns the stored base bits 31:12 with bits 11:0 reading zero.
- R5: The second read goes to {directory entry bits 31:12, linear bits 21:12, 2'b00}. A successful walk returns {table entry bits 31:12, linear bits 11:0}.
- R6: An entry whose bit 0 (present) is clear faults the translation. A non-present directory entry ends the walk after a single read.
- R7: When write protect is set, a write faults if bit 1 (writable) is clear in the directory entry or in the table entry. When write protect is clear, or the access is a read, the writable bits cause no fault.
- R8: A fault loads the faulting linear address into `fault_addr_o`. A translation without a fault leaves that register unchanged.
- R9: `busy_o` is high from the cycle after acceptance through the response cycle. Requests presented while busy are ignored.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, the request and `mem_addr_o` stay unchanged.
- R11: The flags and directory base used by a translation are those in force at acceptance. A control or base write in the acceptance cycle, or during the walk, does not change that translation's outcome.
- R12: `rsp_valid_o` is a single-cycle pulse, and the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| base_we_i | input | 1 | Directory base write strobe |
| base_wdata_i | input | 32 | Directory base write data |
| ctl_o | output | 32 | Control flags readback |
| base_o | output | 32 | Directory base readback |
| fault_addr_o | output | 32 | Last faulting linear address |
| req_valid_i | input | 1 | Translation request |
| req_la_i | input | 32 | Linear address |
| req_write_i | input | 1 | Request is a write |
| busy_o | output | 1 | Translation in progress |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_fault_o | output | 1 | Response is a page fault |
| rsp_paddr_o | output | 32 | Physical address |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 32 | Entry read address |
| mem_ready_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 32 | Entry read data |

## Verification
A register write and the acceptance of a translation can land on the same clock edge. The bench provokes this in two ways. First, it presents a request together with a control write that turns paging off, and then one that turns paging on. Second, it rewrites the directory base and offers a second request in the cycle after acceptance. In each case the outcome is judged against the flags and base that held before the write: the read count, the entry addresses and the physical address must all match those settings. The new register value must then be visible on `ctl_o` or `base_o`.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int unsigned CTL_W    = 32;
  localparam int unsigned PE_BIT   = 0;
  localparam int unsigned WP_BIT   = 16;
  localparam int unsigned PG_BIT   = 31;
  localparam int unsigned PRES_BIT = 0;
  localparam int unsigned WR_BIT   = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_TBL,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/pt_walk_ctl_regs.sv
module pt_walk_ctl_regs
  import pt_walk_pkg::*;
#(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned FRAME_W = LA_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_we_i,
  input  logic [CTL_W-1:0]   ctl_wdata_i,
  input  logic               base_we_i,
  input  logic [LA_W-1:0]    base_wdata_i,
  input  logic               fault_set_i,
  input  logic [LA_W-1:0]    fault_la_i,
  output logic               pg_o,
  output logic               wp_o,
  output logic [FRAME_W-1:0] base_frame_o,
  output logic [CTL_W-1:0]   ctl_o,
  output logic [LA_W-1:0]    base_o,
  output logic [LA_W-1:0]    fault_addr_o
);
  logic pe_q, pg_q, wp_q;
  logic [FRAME_W-1:0] base_q;
  logic [LA_W-1:0]    fault_q;
  logic ctl_legal;
  logic unused_wbits;

  // paging without protection is an illegal combination: drop the word
  assign ctl_legal = !(ctl_wdata_i[PG_BIT] && !ctl_wdata_i[PE_BIT]);
  assign unused_wbits = ^{ctl_wdata_i[PG_BIT-1:WP_BIT+1],
                          ctl_wdata_i[WP_BIT-1:PE_BIT+1],
                          base_wdata_i[OFF_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q    <= 1'b0;
      pg_q    <= 1'b0;
      wp_q    <= 1'b0;
      base_q  <= '0;
      fault_q <= '0;
    end else begin
      if (ctl_we_i && ctl_legal) begin
        pe_q <= ctl_wdata_i[PE_BIT];
        pg_q <= ctl_wdata_i[PG_BIT];
        wp_q <= ctl_wdata_i[WP_BIT];
      end
      if (base_we_i) base_q <= base_wdata_i[LA_W-1:OFF_W];
      if (fault_set_i) fault_q <= fault_la_i;
    end
  end

  always_comb begin
    ctl_o         = '0;
    ctl_o[PE_BIT] = pe_q;
    ctl_o[WP_BIT] = wp_q;
    ctl_o[PG_BIT] = pg_q;
  end

  assign pg_o         = pg_q;
  assign wp_o         = wp_q;
  assign base_frame_o = base_q;
  assign base_o       = {base_q, {OFF_W{1'b0}}};
  assign fault_addr_o = fault_q;

  p_pg_needs_pe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_q |-> pe_q);
  p_fault_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_set_i |=> $stable(fault_addr_o));
endmodule

// File: rtl/pt_walk_entry_addr.sv
module pt_walk_entry_addr #(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned FRAME_W = LA_W - OFF_W,
  localparam int unsigned PAD_W   = OFF_W - IDX_W
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [LA_W-1:0]    addr_o
);
  // one table fills one page: index scaled by entry size
  assign addr_o = {frame_i, idx_i, {PAD_W{1'b0}}};
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
#(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned FRAME_W = LA_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LA_W-1:0]    req_la_i,
  input  logic               req_write_i,
  input  logic               pg_i,
  input  logic               wp_i,
  input  logic [FRAME_W-1:0] base_frame_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [LA_W-1:0]    mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [LA_W-1:0]    mem_rdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [LA_W-1:0]    rsp_paddr_o,
  output logic               fault_set_o,
  output logic [LA_W-1:0]    fault_la_o
);
  walk_state_e state_q, state_d;
  logic [LA_W-1:0]    la_q, la_d, paddr_q, paddr_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic wr_q, wr_d, wp_q, wp_d, dir_w_q, dir_w_d;
  logic [IDX_W-1:0]   idx_sel;
  logic hs, ent_present, ent_wr, wp_block;
  logic [FRAME_W-1:0] ent_frame;
  logic unused_rbits;

  assign idx_sel = (state_q == ST_DIR) ? la_q[LA_W-1 -: IDX_W] : la_q[OFF_W +: IDX_W];

  pt_walk_entry_addr #(.LA_W(LA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_eaddr (
    .frame_i(frame_q),
    .idx_i  (idx_sel),
    .addr_o (mem_addr_o)
  );

  assign mem_req_o    = (state_q == ST_DIR) || (state_q == ST_TBL);
  assign hs           = mem_req_o && mem_ready_i;
  assign ent_present  = mem_rdata_i[PRES_BIT];
  assign ent_wr       = mem_rdata_i[WR_BIT];
  assign ent_frame    = mem_rdata_i[LA_W-1:OFF_W];
  assign unused_rbits = ^mem_rdata_i[OFF_W-1:WR_BIT+1];
  // either level read-only blocks a protected write
  assign wp_block     = wr_q && wp_q && !(dir_w_q && ent_wr);

  always_comb begin
    state_d     = state_q;
    la_d        = la_q;
    wr_d        = wr_q;
    wp_d        = wp_q;
    frame_d     = frame_q;
    dir_w_d     = dir_w_q;
    paddr_d     = paddr_q;
    fault_set_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        la_d = req_la_i;
        wr_d = req_write_i;
        wp_d = wp_i;
        if (pg_i) begin
          frame_d = base_frame_i;
          state_d = ST_DIR;
        end else begin
          paddr_d = req_la_i;
          state_d = ST_DONE;
        end
      end
      ST_DIR: if (hs) begin
        if (!ent_present) begin
          state_d     = ST_FAULT;
          fault_set_o = 1'b1;
        end else begin
          frame_d = ent_frame;
          dir_w_d = ent_wr;
          state_d = ST_TBL;
        end
      end
      ST_TBL: if (hs) begin
        if (!ent_present || wp_block) begin
          state_d     = ST_FAULT;
          fault_set_o = 1'b1;
        end else begin
          paddr_d = {ent_frame, la_q[OFF_W-1:0]};
          state_d = ST_DONE;
        end
      end
      ST_DONE, ST_FAULT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      la_q    <= '0;
      wr_q    <= 1'b0;
      wp_q    <= 1'b0;
      frame_q <= '0;
      dir_w_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      la_q    <= la_d;
      wr_q    <= wr_d;
      wp_q    <= wp_d;
      frame_q <= frame_d;
      dir_w_q <= dir_w_d;
      paddr_q <= paddr_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign rsp_valid_o = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_fault_o = (state_q == ST_FAULT);
  assign rsp_paddr_o = paddr_q;
  assign fault_la_o  = la_q;

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));
  p_rsp_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && !busy_o);
  p_accept_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);
endmodule

// File: rtl/pt_walk_top.sv
module pt_walk_top
  import pt_walk_pkg::*;
#(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned FRAME_W = LA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             base_we_i,
  input  logic [LA_W-1:0]  base_wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [LA_W-1:0]  base_o,
  output logic [LA_W-1:0]  fault_addr_o,
  input  logic             req_valid_i,
  input  logic [LA_W-1:0]  req_la_i,
  input  logic             req_write_i,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [LA_W-1:0]  rsp_paddr_o,
  output logic             mem_req_o,
  output logic [LA_W-1:0]  mem_addr_o,
  input  logic             mem_ready_i,
  input  logic [LA_W-1:0]  mem_rdata_i
);
  logic pg, wp, fault_set;
  logic [FRAME_W-1:0] base_frame;
  logic [LA_W-1:0]    fault_la;

  pt_walk_ctl_regs #(.LA_W(LA_W), .OFF_W(OFF_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .base_we_i   (base_we_i),
    .base_wdata_i(base_wdata_i),
    .fault_set_i (fault_set),
    .fault_la_i  (fault_la),
    .pg_o        (pg),
    .wp_o        (wp),
    .base_frame_o(base_frame),
    .ctl_o       (ctl_o),
    .base_o      (base_o),
    .fault_addr_o(fault_addr_o)
  );

  pt_walk_fsm #(.LA_W(LA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_la_i    (req_la_i),
    .req_write_i (req_write_i),
    .pg_i        (pg),
    .wp_i        (wp),
    .base_frame_i(base_frame),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_paddr_o (rsp_paddr_o),
    .fault_set_o (fault_set),
    .fault_la_o  (fault_la)
  );

  p_fault_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> fault_addr_o == fault_la);
  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && !pg |=>
      rsp_valid_o && !rsp_fault_o && rsp_paddr_o == $past(req_la_i));
endmodule

// File: tb/pt_walk_top_tb_top.sv
module pt_walk_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DIR_BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, base_we = 1'b0;
  logic [31:0] ctl_wdata = '0, base_wdata = '0;
  logic [31:0] ctl_rd, base_rd, fault_addr;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_la = '0;
  logic busy, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;
  logic mem_req, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;

  int checks = 0, errors = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] exp_fault_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walk_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .ctl_o(ctl_rd), .base_o(base_rd), .fault_addr_o(fault_addr),
    .req_valid_i(req_valid), .req_la_i(req_la), .req_write_i(req_write),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // entries: directory page at DIR_BASE, table page for index d at frame 0x20+d
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [9:0] di, ti;
    logic [19:0] fr;
    fr = a[31:12];
    ti = a[11:2];
    if (fr == DIR_BASE[31:12]) begin
      di = ti;
      return {20'h00020 + 20'(di), 10'b0, di[1:0] != 2'd2, di[1:0] != 2'd3};
    end else if (fr >= 20'h00020 && fr < 20'h00420) begin
      di = 10'(fr - 20'h00020);
      return {20'((int'(di) * 37 + int'(ti) * 11 + 5) & 32'hFFFFF), 10'b0,
              ti[1:0] != 2'd1, ti[1:0] != 2'd3};
    end
    return 32'h0;
  endfunction

  int lat = 0, wait_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (wait_cnt >= lat) begin
          mem_ready = 1'b1;
          mem_rdata = mem_word(mem_addr);
          if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
          rd_cnt++;
          wait_cnt = 0;
          lat = (lat + 1) % 3;
        end else begin
          mem_ready = 1'b0;
          wait_cnt++;
        end
      end else begin
        mem_ready = 1'b0;
      end
    end
  end

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] la, input bit wr,
                       input bit do_ctl, input logic [31:0] ctl_v, input bit disturb,
                       output logic [31:0] pa, output bit flt, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_la = la; req_write = wr; rd_cnt = 0;
    if (do_ctl) begin ctl_we = 1'b1; ctl_wdata = ctl_v; end
    @(negedge clk);
    req_valid = 1'b0; ctl_we = 1'b0;
    check(busy === 1'b1, "R9 busy after accept", 32'(busy), 32'd1);
    if (disturb) begin
      req_valid = 1'b1; req_la = ~la; base_we = 1'b1; base_wdata = 32'h00AB_C000;
    end
    cyc = 1;
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      req_valid = 1'b0; base_we = 1'b0;
      cyc++;
    end
    pa = rsp_paddr; flt = rsp_fault;
    if (flt) check(fault_addr === la, "R8 fault address", fault_addr, la);
    @(negedge clk);
    req_valid = 1'b0; base_we = 1'b0;
    check(!rsp_valid && !busy, "R12 single pulse then idle", {rsp_valid, busy}, 32'd0);
  endtask

  task automatic run_walk(input logic [31:0] la, input bit wr, input bit wp,
                          input bit do_ctl, input logic [31:0] ctl_v, input bit disturb);
    logic [31:0] pde, pte, a0, a1, pa, epa;
    bit flt, ef;
    int cyc, erd;
    a0  = {DIR_BASE[31:12], la[31:22], 2'b00};
    pde = mem_word(a0);
    a1  = {pde[31:12], la[21:12], 2'b00};
    pte = mem_word(a1);
    epa = {pte[31:12], la[11:0]};
    ef  = !pde[0] || !pte[0] || (wr && wp && (!pde[1] || !pte[1]));
    erd = pde[0] ? 2 : 1;
    xlate(la, wr, do_ctl, ctl_v, disturb, pa, flt, cyc);
    if (!pde[0]) check(flt, "R6 directory not present", 32'(flt), 32'd1);
    else if (!pte[0]) check(flt, "R6 table not present", 32'(flt), 32'd1);
    else check(flt == ef, "R7 write protect outcome", 32'(flt), 32'(ef));
    check(rd_cnt == erd, "R6 read count", 32'(rd_cnt), 32'(erd));
    check(rd_addr[0] === a0, "R4 directory entry address", rd_addr[0], a0);
    if (pde[0]) check(rd_addr[1] === a1, "R5 table entry address", rd_addr[1], a1);
    if (!ef) check(pa === epa, "R5 physical address", pa, epa);
    if (ef) exp_fault_addr = la;
    check(fault_addr === exp_fault_addr, "R8 fault register", fault_addr, exp_fault_addr);
  endtask

  task automatic run_bypass(input logic [31:0] la, input bit wr,
                            input bit do_ctl, input logic [31:0] ctl_v);
    logic [31:0] pa;
    bit flt;
    int cyc;
    xlate(la, wr, do_ctl, ctl_v, 1'b0, pa, flt, cyc);
    check(pa === la && !flt, "R3 bypass address", pa, la);
    check(cyc == 1, "R3 bypass latency", 32'(cyc), 32'd1);
    check(rd_cnt == 0, "R3 no memory reads", 32'(rd_cnt), 32'd0);
    check(fault_addr === exp_fault_addr, "R8 unchanged on bypass", fault_addr, exp_fault_addr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctl_rd === 0 && base_rd === 0 && fault_addr === 0, "R1 registers zero",
          ctl_rd | base_rd | fault_addr, 32'd0);
    check(!busy && !rsp_valid && !mem_req, "R1 idle outputs",
          {busy, rsp_valid, mem_req}, 32'd0);
    rst_n = 1'b1;

    // R2 control word
    wr_ctl(32'hFFFF_FFFF);
    check(ctl_rd === 32'h8001_0001, "R2 flag readback", ctl_rd, 32'h8001_0001);
    wr_ctl(32'h8000_0000);
    check(ctl_rd === 32'h8001_0001, "R2 illegal write ignored", ctl_rd, 32'h8001_0001);
    wr_ctl(32'h0);
    check(ctl_rd === 32'h0, "R2 clear", ctl_rd, 32'h0);
    wr_ctl(32'h8001_0000);
    check(ctl_rd === 32'h0, "R2 illegal write ignored from zero", ctl_rd, 32'h0);
    wr_ctl(32'h0001_0001);
    check(ctl_rd === 32'h0001_0001, "R2 protect and wp", ctl_rd, 32'h0001_0001);
    wr_base(DIR_BASE | 32'hABC);
    check(base_rd === DIR_BASE, "R4 base readback", base_rd, DIR_BASE);

    // R3 paging off
    for (int i = 0; i < 8; i++) run_bypass(32'h1357_9BDF * (i + 1), i[0], 1'b0, 32'h0);

    // R4..R8 sweep
    for (int wp = 0; wp < 2; wp++) begin
      wr_ctl(wp[0] ? 32'h8001_0001 : 32'h8000_0001);
      for (int d = 0; d < 8; d++)
        for (int t = 0; t < 8; t++)
          for (int w = 0; w < 2; w++) begin
            logic [9:0] di, ti;
            di = 10'((d * 137 + 3) & 1023);
            ti = 10'((t * 71 + d * 5) & 1023);
            run_walk({di, ti, 12'((d * 7 + t * 13 + w) * 37)}, w[0], wp[0], 1'b0, 32'h0, 1'b0);
          end
    end

    // R11 control write in the acceptance cycle
    wr_ctl(32'h8000_0001);
    run_walk({10'd4, 10'd2, 12'h123}, 1'b1, 1'b0, 1'b1, 32'h0, 1'b0);
    check(ctl_rd === 32'h0, "R11 new control visible", ctl_rd, 32'h0);
    run_bypass({10'd4, 10'd2, 12'h456}, 1'b0, 1'b1, 32'h8001_0001);
    check(ctl_rd === 32'h8001_0001, "R11 paging now on", ctl_rd, 32'h8001_0001);
    // R11 and R9: base rewrite and a second request during a walk
    run_walk({10'd5, 10'd6, 12'h789}, 1'b0, 1'b1, 1'b0, 32'h0, 1'b1);
    check(base_rd === 32'h00AB_C000, "R11 base written mid walk", base_rd, 32'h00AB_C000);
    check(rd_cnt == 2, "R9 busy request ignored", 32'(rd_cnt), 32'd2);
    wr_base(DIR_BASE);
    run_walk({10'd8, 10'd8, 12'hFFF}, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule